// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 16-bit virtual address into a 16-bit physical address through a four-entry segment table held on chip. The top two bits of the virtual address pick a table entry; the remaining fourteen bits are an offset. Each entry stores a base address, an inclusive maximum offset, a valid flag, and separate read and write permissions. The physical address is the base plus the offset. A request that cannot be honoured returns a fault flag and a cause code instead of an address.

Entries are loaded through a configuration write port. That port only accepts a write when its privilege input is high. Translation requests come with an access-type bit (0 = read, 1 = write). The response is registered and appears exactly one cycle after the request.

Top module: `seg_xlate_unit`

## Requirements
- R1: Virtual bits 15:14 select the entry and bits 13:0 form the offset. A permitted request returns rsp_paddr = base + offset with rsp_fault = 0 and rsp_cause = 0.
- R2: An offset greater than the entry's limit faults with cause 2. An offset equal to the limit translates normally.
- R3: A request to an entry whose valid flag is clear faults with cause 1.
- R4: A read (req_write = 0) needs the entry's read permission. A write (req_write = 1) needs its write permission. A request lacking the needed permission faults with cause 3.
- R5: When several faults apply, the reported cause is the first of this list: invalid (1), limit (2), permission (3), overflow (4).
- R6: If base + offset exceeds 0xFFFF, the request faults with cause 4. A sum of exactly 0xFFFF translates normally.
- R7: A configuration write with cfg_priv = 0 leaves the table unchanged.
- R8: A privileged table write affects requests from the next cycle on. A request in the same cycle as the write sees the old entry.
- R9: Reset clears every entry to not-valid and drives rsp_valid low.
- R10: rsp_fault is high exactly when rsp_cause is nonzero. A faulted response carries rsp_paddr = 0.
- R11: rsp_valid equals req_valid of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Writer is privileged; writes are ignored when low |
| cfg_idx | input | 2 | Entry to write |
| cfg_valid | input | 1 | New valid flag |
| cfg_rd | input | 1 | New read permission |
| cfg_wr | input | 1 | New write permission |
| cfg_base | input | 16 | New base address |
| cfg_limit | input | 14 | New maximum offset (inclusive) |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | Access type: 1 = write, 0 = read |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 16 | Physical address; 0 on fault |
| rsp_fault | output | 1 | Access error |
| rsp_cause | output | 3 | 0 none, 1 invalid, 2 limit, 3 permission, 4 overflow |

## Verification
The following are checked on every cycle by assertions:
- the response strobe tracks the previous cycle's request strobe;
- the fault flag agrees with the cause code;
- a faulted address is zero;
- an invalid entry never yields a clean translation;
- an unprivileged write never disturbs the table;
- reset leaves every entry not-valid.

Only the bench scenarios can show the rest: the exact sums, the boundaries at limit and at 0xFFFF, the permission split between reads and writes, and the cause priority when faults combine. The same holds for the old-contents behaviour when a write and a request meet in one cycle.

// File: rtl/segx_pkg.sv
package segx_pkg;
    localparam int VA_W  = 16;
    localparam int SEG_W = 2;
    localparam int PA_W  = 16;
    localparam int OFF_W = VA_W - SEG_W;
    localparam int NSEG  = 1 << SEG_W;

    typedef struct packed {
        logic             valid;
        logic             rd_ok;
        logic             wr_ok;
        logic [PA_W-1:0]  base;
        logic [OFF_W-1:0] limit;
    } seg_entry_t;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_INVALID  = 3'd1,
        CAUSE_LIMIT    = 3'd2,
        CAUSE_PERM     = 3'd3,
        CAUSE_OVERFLOW = 3'd4
    } cause_e;

    typedef struct packed {
        logic            fault;
        cause_e          cause;
        logic [PA_W-1:0] paddr;
    } xlat_res_t;

    // Fixed priority: invalid, limit, permission, overflow.
    function automatic cause_e pick_cause(input logic ok_valid, input logic over_limit,
                                          input logic perm_bad, input logic carry);
        if (!ok_valid)       return CAUSE_INVALID;
        else if (over_limit) return CAUSE_LIMIT;
        else if (perm_bad)   return CAUSE_PERM;
        else if (carry)      return CAUSE_OVERFLOW;
        else                 return CAUSE_NONE;
    endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
    import segx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             priv,
    input  logic [SEG_W-1:0] widx,
    input  seg_entry_t       wdata,
    input  logic [SEG_W-1:0] ridx,
    output seg_entry_t       rdata
);
    seg_entry_t tbl [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                tbl[g] <= '0;
            else if (we && priv && (widx == SEG_W'(g)))
                tbl[g] <= wdata;
        end

        // R7: unprivileged writes do not alter any entry
        p_user_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(we && !priv)) |-> $stable(tbl[g]));

        // R9: entries are not-valid right after reset
        p_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !tbl[g].valid);
    end

    assign rdata = tbl[ridx];
endmodule

// File: rtl/seg_check.sv
module seg_check
    import segx_pkg::*;
(
    input  seg_entry_t       ent,
    input  logic [OFF_W-1:0] offset,
    input  logic             is_write,
    output xlat_res_t        res
);
    logic [PA_W:0] sum;
    logic          over_limit;
    logic          perm_bad;
    cause_e        cause;

    always_comb begin
        sum        = {1'b0, ent.base} + (PA_W+1)'(offset);
        over_limit = offset > ent.limit;
        perm_bad   = is_write ? !ent.wr_ok : !ent.rd_ok;
        cause      = pick_cause(ent.valid, over_limit, perm_bad, sum[PA_W]);
        res.cause  = cause;
        res.fault  = (cause != CAUSE_NONE);
        res.paddr  = (cause != CAUSE_NONE) ? '0 : sum[PA_W-1:0];
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import segx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_priv,
    input  logic [1:0]  cfg_idx,
    input  logic        cfg_valid,
    input  logic        cfg_rd,
    input  logic        cfg_wr,
    input  logic [15:0] cfg_base,
    input  logic [13:0] cfg_limit,
    input  logic        req_valid,
    input  logic [15:0] req_vaddr,
    input  logic        req_write,
    output logic        rsp_valid,
    output logic [15:0] rsp_paddr,
    output logic        rsp_fault,
    output logic [2:0]  rsp_cause
);
    seg_entry_t wentry;
    seg_entry_t sel;
    xlat_res_t  res;

    assign wentry = '{valid: cfg_valid, rd_ok: cfg_rd, wr_ok: cfg_wr,
                      base: cfg_base, limit: cfg_limit};

    seg_table u_tbl (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .priv  (cfg_priv),
        .widx  (cfg_idx),
        .wdata (wentry),
        .ridx  (req_vaddr[VA_W-1 -: SEG_W]),
        .rdata (sel)
    );

    seg_check u_chk (
        .ent      (sel),
        .offset   (req_vaddr[OFF_W-1:0]),
        .is_write (req_write),
        .res      (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_paddr <= res.paddr;
            rsp_fault <= res.fault;
            rsp_cause <= res.cause;
        end
    end

    // R11: response strobe follows request strobe by one cycle
    p_rsp_tracks_req_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid)));

    // R10: fault flag consistent with cause code
    p_fault_flag_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

    // R10: faulted responses carry a zero address
    p_fault_zero_addr_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R3: a not-valid entry always reports the invalid cause
    p_invalid_faults_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(sel.valid)) |-> (rsp_cause == 3'd1));
endmodule

// File: tb/tb_seg_xlate_unit.sv
`timescale 1ns/1ps
module tb_seg_xlate_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_priv, cfg_valid, cfg_rd, cfg_wr;
    logic [1:0]  cfg_idx;
    logic [15:0] cfg_base;
    logic [13:0] cfg_limit;
    logic        req_valid, req_write;
    logic [15:0] req_vaddr;
    logic        rsp_valid, rsp_fault;
    logic [15:0] rsp_paddr;
    logic [2:0]  rsp_cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_xlate_unit dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
        .cfg_valid(cfg_valid), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    // {vaddr, write, cause, paddr}
    localparam int NV = 11;
    localparam logic [35:0] VEC [NV] = '{
        {16'h0240, 1'b0, 3'd0, 16'h4240},  // R1 seg0 read
        {16'h0240, 1'b1, 3'd3, 16'h0000},  // R4 write to read-only
        {16'h4050, 1'b0, 3'd0, 16'h4850},  // R1 seg1 read
        {16'h4050, 1'b1, 3'd0, 16'h4850},  // R4 write allowed
        {16'h43FF, 1'b0, 3'd0, 16'h4BFF},  // R2 offset == limit
        {16'h4400, 1'b0, 3'd2, 16'h0000},  // R2 offset > limit
        {16'h8000, 1'b0, 3'd1, 16'h0000},  // R3 invalid entry
        {16'h8000, 1'b1, 3'd1, 16'h0000},  // R5 invalid over permission
        {16'hCFFF, 1'b0, 3'd0, 16'hFFFF},  // R6 sum exactly 0xFFFF
        {16'hD000, 1'b0, 3'd4, 16'h0000},  // R6 carry out
        {16'h0400, 1'b1, 3'd2, 16'h0000}   // R5 limit over permission
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic priv, input logic v,
                      input logic r, input logic w, input logic [15:0] b, input logic [13:0] l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = priv; cfg_idx = idx; cfg_valid = v;
        cfg_rd = r; cfg_wr = w; cfg_base = b; cfg_limit = l;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xl(input string tag, input logic [15:0] va, input logic w,
                      input logic [2:0] cause, input logic [15:0] pa);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = w;
        @(posedge clk); #1;
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " cause"}, 32'(rsp_cause), 32'(cause));
        chk({tag, " fault R10"}, 32'(rsp_fault), 32'(cause != 3'd0));
        chk({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_priv = 0; cfg_idx = 0; cfg_valid = 0;
        cfg_rd = 0; cfg_wr = 0; cfg_base = 0; cfg_limit = 0;
        req_valid = 0; req_vaddr = 0; req_write = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        xl("R9 entry0 invalid after reset", 16'h0000, 1'b0, 3'd1, 16'h0000);
        xl("R9 entry3 invalid after reset", 16'hC000, 1'b0, 3'd1, 16'h0000);

        wr(2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h4000, 14'h03FF);
        wr(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h4800, 14'h03FF);
        wr(2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 16'hF000, 14'h3FFF);

        for (int i = 0; i < NV; i++)
            xl($sformatf("vec%0d", i), VEC[i][35:20], VEC[i][19], VEC[i][18:16], VEC[i][15:0]);

        // R7: unprivileged write to entry 2 is dropped
        wr(2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 16'h1000, 14'h3FFF);
        xl("R7 user write ignored", 16'h8010, 1'b0, 3'd1, 16'h0000);
        // R7: unprivileged overwrite of entry 1 is dropped
        wr(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 14'h0000);
        xl("R7 entry1 kept", 16'h4050, 1'b0, 3'd0, 16'h4850);

        // R8: same-cycle write and request
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = 1'b1; cfg_idx = 2'd2; cfg_valid = 1'b1;
        cfg_rd = 1'b1; cfg_wr = 1'b1; cfg_base = 16'h1000; cfg_limit = 14'h3FFF;
        req_valid = 1'b1; req_vaddr = 16'h8010; req_write = 1'b0;
        @(posedge clk); #1;
        chk("R8 same-cycle sees old cause", 32'(rsp_cause), 32'd1);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R11 idle rsp_valid low", 32'(rsp_valid), 32'd0);
        xl("R8 next cycle sees new entry", 16'h8010, 1'b0, 3'd0, 16'h1010);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule